// File: doc/BRIEF.md
# Serial Conversion Frame Sequencer

This block is the digital half of a sampling converter's three-wire serial port. A host raises a conversion-start line and then clocks the block with a serial clock. The rising edge of conversion-start, as seen at a serial clock rising edge, opens a frame that lasts fourteen serial clock cycles. Within that frame the block drives a single status bit (the reference-ready flag) and then a 12-bit result, most significant bit first, on a data line that can be disabled. The result is taken from a parallel port that stands in for the analog core.

The data line carries a separate enable. Outside a frame, and during the first cycle of a frame, the enable is low and the data value is held at zero. Each new bit is launched on a serial clock rising edge, so the host can capture it on the next rising edge while it is stable. Further rising edges on conversion-start inside a running frame are ignored. Only the edge matters, so the start line may stay high for as long as the host likes.

Top module: `conv_serial_seq`

## Requirements
- R1: After reset, `dout_oe` is 0 and `dout` is 0, and they stay so until a start is accepted.
- R2: A start is accepted at a serial clock rising edge (frame edge 1) where `conv` is 1 and was 0 at the previous rising edge, provided no frame is running or the running frame has reached its last cycle. `dout_oe` stays 0 after edge 1.
- R3: After frame edge 2, `dout_oe` is 1 and `dout` carries the value that `ref_ok` had at that edge.
- R4: After frame edge k, for k from 3 to 14, `dout_oe` is 1 and `dout` equals `sample[14-k]`. The result is therefore sent MSB first.
- R5: The 12-bit `sample` is captured at frame edge 1. Later changes on `sample` do not alter the bits sent in that frame.
- R6: Rising edges of `conv` seen at frame edges 2 to 14 are ignored. The frame runs on unchanged, and no new frame follows from those edges.
- R7: After frame edge 15, `dout_oe` returns to 0 and `dout` to 0. Whenever `dout_oe` is 0, `dout` is 0.
- R8: If `conv` stays high across the whole frame and beyond it, no further frame starts until `conv` falls and rises again.
- R9: A start whose rising edge is seen at frame edge 15 is accepted at once. That edge becomes edge 1 of a new frame, and its status bit follows at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv | input | 1 | Conversion-start; its rising edge opens a frame |
| sample | input | 12 | Parallel result from the converter core |
| ref_ok | input | 1 | Reference-ready status flag |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Drive enable for the data line (0 = high impedance) |

## Verification
The sequencer is driven with several kinds of frame. In a plain frame the start line falls after one cycle. A second frame sends a different result and the opposite status value, which tells a correct bit order apart from a reversed or stale one. Changing the parallel input right after capture shows whether the result is held. Extra start pulses inside a frame, and a start line held high throughout, show whether retriggering is properly suppressed. A start edge timed exactly at the closing cycle shows whether the frame boundary is placed correctly and whether frames can run back to back.

// File: rtl/conv_serial_pkg.sv
package conv_serial_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REF  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;
endpackage

// File: rtl/conv_edge_det.sv
module conv_edge_det (
    input  logic sck,
    input  logic rst_n,
    input  logic conv,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } det_s;

    det_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = conv;
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = conv & ~st_q.prev;
endmodule

// File: rtl/conv_frame_seq.sv
module conv_frame_seq
    import conv_serial_pkg::*;
#(
    parameter int FRAME_LEN = 14
) (
    input  logic   sck,
    input  logic   rst_n,
    input  logic   start,
    output logic   load,
    output phase_e phase
);
    localparam int CW = $clog2(FRAME_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } seq_s;

    seq_s st_d, st_q;
    logic accept;

    always_comb begin
        accept = start && ((st_q.cnt == '0) || (st_q.cnt == LAST));
        st_d   = st_q;
        if (accept)
            st_d.cnt = CW'(1);
        else if (st_q.cnt != '0 && st_q.cnt != LAST)
            st_d.cnt = st_q.cnt + CW'(1);
        else
            st_d.cnt = '0;
    end

    always_comb begin
        if (st_q.cnt == CW'(1))
            phase = PH_REF;
        else if (st_q.cnt >= CW'(2) && st_q.cnt < LAST)
            phase = PH_DATA;
        else
            phase = PH_IDLE;
    end

    assign load = accept;

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: inside a frame the count advances by one whatever conv does
    assert_frame_advances_R6: assert property (@(posedge sck) disable iff (!rst_n)
        (st_q.cnt != '0 && st_q.cnt != LAST) |=> st_q.cnt == $past(st_q.cnt) + CW'(1));

    // R2: the count never passes the frame length
    assert_count_bounded_R2: assert property (@(posedge sck) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R9: a start at the last cycle restarts the count at one
    assert_restart_R9: assert property (@(posedge sck) disable iff (!rst_n)
        (st_q.cnt == LAST && start) |=> st_q.cnt == CW'(1));
endmodule

// File: rtl/conv_out_shift.sv
module conv_out_shift
    import conv_serial_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              sck,
    input  logic              rst_n,
    input  logic              load,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] sample,
    input  logic              ref_ok,
    output logic              dout,
    output logic              dout_oe
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit_o;
        logic              oe;
    } sh_s;

    sh_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (phase)
            PH_REF: begin
                st_d.bit_o = ref_ok;
                st_d.oe    = 1'b1;
            end
            PH_DATA: begin
                st_d.bit_o = st_q.data[DATA_W-1];
                st_d.data  = {st_q.data[DATA_W-2:0], 1'b0};
                st_d.oe    = 1'b1;
            end
            default: begin
                st_d.bit_o = 1'b0;
                st_d.oe    = 1'b0;
            end
        endcase
        if (load)
            st_d.data = sample;
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.bit_o;
    assign dout_oe = st_q.oe;

    // R7: a disabled line always carries zero
    assert_quiet_when_off_R7: assert property (@(posedge sck) disable iff (!rst_n)
        !dout_oe |-> !dout);

    // R2: the cycle after an accepted start leaves the line disabled
    assert_first_cycle_off_R2: assert property (@(posedge sck) disable iff (!rst_n)
        load |=> !dout_oe);

    // R3: the status phase drives the line with ref_ok
    assert_ref_bit_R3: assert property (@(posedge sck) disable iff (!rst_n)
        (phase == PH_REF) |=> (dout_oe && dout == $past(ref_ok)));
endmodule

// File: rtl/conv_serial_seq.sv
module conv_serial_seq
    import conv_serial_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              sck,
    input  logic              rst_n,
    input  logic              conv,
    input  logic [DATA_W-1:0] sample,
    input  logic              ref_ok,
    output logic              dout,
    output logic              dout_oe
);
    localparam int FRAME_LEN = DATA_W + 2;

    logic   rise;
    logic   load;
    phase_e phase;

    conv_edge_det u_det (
        .sck   (sck),
        .rst_n (rst_n),
        .conv  (conv),
        .rise  (rise)
    );

    conv_frame_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
        .sck   (sck),
        .rst_n (rst_n),
        .start (rise),
        .load  (load),
        .phase (phase)
    );

    conv_out_shift #(.DATA_W(DATA_W)) u_sh (
        .sck     (sck),
        .rst_n   (rst_n),
        .load    (load),
        .phase   (phase),
        .sample  (sample),
        .ref_ok  (ref_ok),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    // R8: a start line that stays high yields no accepted start
    assert_held_high_no_start_R8: assert property (@(posedge sck) disable iff (!rst_n)
        ($past(conv) && conv) |-> !load);
endmodule

// File: tb/conv_serial_seq_test.sv
module conv_serial_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv = 1'b0;
    logic [11:0] sample = '0;
    logic        ref_ok = 1'b0;
    logic        dout, dout_oe;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    conv_serial_seq uut (
        .sck(clk), .rst_n(rst_n), .conv(conv), .sample(sample),
        .ref_ok(ref_ok), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: {oe,dout} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Edges 2..14 of a frame; optional conv pulses and a final start at edge 15.
    task automatic stream(input logic [11:0] s, input logic r, input bit pulses, input bit chain);
        for (int k = 2; k <= 14; k++) begin
            @(negedge clk);
            if (k == 2) begin
                chk("R3", {dout_oe, dout}, {1'b1, r});
                ref_ok = ~r;
            end else begin
                chk(pulses ? "R6" : "R4", {dout_oe, dout}, {1'b1, s[14-k]});
            end
            if (pulses && (k == 4 || k == 9 || k == 13)) conv = 1'b1;
            if (pulses && (k == 5 || k == 10)) conv = 1'b0;
            if (k == 13) conv = 1'b0;
            if (chain && k == 14) conv = 1'b1;
        end
    endtask

    task automatic open_frame(input logic [11:0] s, input logic r, input logic [11:0] later, input bit hold);
        @(negedge clk);
        conv = 1'b1; sample = s; ref_ok = r;
        @(negedge clk);
        chk("R2", {dout_oe, dout}, 2'b00);
        sample = later;
        if (!hold) conv = 1'b0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", {dout_oe, dout}, 2'b00);
        end
    endtask

    task automatic t_plain(input logic [11:0] s, input logic r);
        open_frame(s, r, s, 1'b0);
        stream(s, r, 1'b0, 1'b0);
        @(negedge clk);
        chk("R7", {dout_oe, dout}, 2'b00);
    endtask

    task automatic t_capture;
        open_frame(12'hA5C, 1'b1, 12'h3F0, 1'b0);
        for (int i = 0; i < 12; i++) sample = ~sample;
        stream(12'hA5C, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        chk("R5", {dout_oe, dout}, 2'b00);
    endtask

    task automatic t_pulses;
        open_frame(12'h6D3, 1'b0, 12'h000, 1'b0);
        stream(12'h6D3, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6", {dout_oe, dout}, 2'b00);
        end
    endtask

    task automatic t_hold;
        open_frame(12'h1E7, 1'b1, 12'h1E7, 1'b1);
        for (int k = 2; k <= 14; k++) begin
            @(negedge clk);
            chk("R8", {dout_oe, dout}, {1'b1, (k == 2) ? 1'b1 : sample[14-k]});
        end
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R8", {dout_oe, dout}, 2'b00);
        end
        conv = 1'b0;
        @(negedge clk);
        chk("R8", {dout_oe, dout}, 2'b00);
    endtask

    task automatic t_chain;
        open_frame(12'hC31, 1'b1, 12'hC31, 1'b0);
        stream(12'hC31, 1'b1, 1'b0, 1'b1);
        sample = 12'h59E; ref_ok = 1'b0;
        @(negedge clk);
        chk("R9", {dout_oe, dout}, 2'b00);
        conv = 1'b0;
        sample = 12'h000;
        stream(12'h59E, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R9", {dout_oe, dout}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain(12'hB2D, 1'b1);
        t_plain(12'h4D2, 1'b0);
        t_plain(12'h801, 1'b1);
        t_capture();
        t_pulses();
        t_hold();
        t_chain();
        t_plain(12'hFFF, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule